// File: doc/BRIEF.md
# Ramp-Scan Rank Sorter

This block assigns a magnitude rank to each of K unsigned N-bit values without comparing any pair of them. After a start pulse, an internal ramp counts up from zero to full scale, where full scale is 2^N. Each input has its own threshold detector. The detector trips on the first ramp step at which the input plus the ramp reaches full scale. The largest value therefore trips first, and a zero value trips on the last step.

A single shared counter holds how many detectors tripped on earlier steps. When a detector trips, its rank register stores the counter value from that step. The result is a competition ranking: each input's rank equals the number of inputs that are strictly larger than it.

The caller holds the data inputs steady from the start pulse until done. The ranks can then be read until the next start. The control pins are plain level and pulse signals with no back-pressure. The block accepts a start only when no scan is running, and it drops a start that arrives during a scan. The results need no acknowledge: they stay valid until the next accepted start.

Top module: `rsort_rank_scan`

## Requirements
- R1: While rst_n is low and after its release, done is 0 and every rank field reads 0.
- R2: A start accepted on a clock edge makes done rise exactly 2^N+1 clock edges later. In between, the ramp advances by one on every edge.
- R3: For distinct inputs, the largest gets rank 0, the next largest rank 1, and so on up to K-1. Rank field i occupies bits [i*RW +: RW] of rank, where RW = clog2(K). Input i occupies din[i*N +: N].
- R4: Inputs of equal value trip on the same ramp step and get the same rank. That rank equals the count of strictly larger inputs.
- R5: An input of 0 trips on the final ramp step, so every detector has tripped by the time done is 1. If all inputs are 0, all ranks are 0.
- R6: Each detector trips at most once per scan. While done stays high, the rank outputs and done do not change.
- R7: A start pulse during a running scan is ignored: done timing and ranks are as if it never came.
- R8: A start accepted after done clears done on the same edge and begins a fresh scan that carries no state from the previous one.
- R9: Inputs that differ by one LSB (full scale / 2^N) get different ranks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a scan when no scan is running |
| din | input | K*N | Packed input values, held stable during a scan |
| rank | output | K*RW | Packed rank codes, one per input |
| done | output | 1 | High from scan end until the next accepted start |

## Verification
Only two timings matter: done and the final ranks appear 2^N+1 edges after the start edge, and done goes low one edge after a restart. The driver records the cycle count at the first falling edge after the start edge and queues the expected ranks, which it derives by counting strictly larger inputs. The monitor samples on falling edges. At the rising edge of done it checks both the elapsed cycle count and the ranks. The driver then checks that the results hold for four more cycles, and that done is already low one cycle after each start.

// File: rtl/rsort_pkg.sv
package rsort_pkg;
  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_RUN  = 2'd1,
    SC_DONE = 2'd2
  } scan_state_t;
endpackage

// File: rtl/rsort_ramp.sv
module rsort_ramp
  import rsort_pkg::*;
#(
  parameter int N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic [N:0] ramp,
  output logic       scan_en,
  output logic       clr,
  output logic       done
);
  localparam logic [N:0] FULL = {1'b1, {N{1'b0}}};

  scan_state_t state_q;
  logic [N:0]  ramp_q;

  assign clr     = start && (state_q != SC_RUN);
  assign scan_en = (state_q == SC_RUN);
  assign done    = (state_q == SC_DONE);
  assign ramp    = ramp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      ramp_q  <= '0;
    end else if (clr) begin
      state_q <= SC_RUN;
      ramp_q  <= '0;
    end else if (state_q == SC_RUN) begin
      if (ramp_q == FULL) state_q <= SC_DONE;
      else                ramp_q  <= ramp_q + 1'b1;
    end
  end

  // R2: the ramp climbs one step per cycle until full scale
  a_r2_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SC_RUN && ramp_q != FULL) |=> (state_q == SC_RUN && ramp_q == $past(ramp_q) + 1'b1));

  // R7: a start during a scan never sends the ramp back to zero
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SC_RUN && start) |=> (ramp_q != '0));
endmodule

// File: rtl/rsort_cell.sv
module rsort_cell #(
  parameter int N  = 4,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          scan_en,
  input  logic [N:0]    ramp,
  input  logic [N-1:0]  din,
  input  logic [RW-1:0] code,
  output logic          fire,
  output logic          fired,
  output logic [RW-1:0] rank
);
  localparam logic [N+1:0] FS_EXT = (N+2)'(1) << N;

  logic [N+1:0]  level;
  logic          fired_q;
  logic [RW-1:0] rank_q;

  // trips once value plus ramp reaches full scale
  assign level = {2'b00, din} + {1'b0, ramp};
  assign fire  = scan_en && !fired_q && (level >= FS_EXT);
  assign fired = fired_q;
  assign rank  = rank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      rank_q  <= '0;
    end else if (clr) begin
      fired_q <= 1'b0;
      rank_q  <= '0;
    end else if (fire) begin
      fired_q <= 1'b1;
      rank_q  <= code;
    end
  end

  // R6: a tripped detector stays tripped until the next start
  a_r6_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !clr) |=> fired_q);

  // R6: the latched rank holds once captured
  a_r6_rank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !clr) |=> $stable(rank_q));
endmodule

// File: rtl/rsort_popcnt.sv
module rsort_popcnt #(
  parameter int K  = 4,
  parameter int CW = 3,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [K-1:0]  fire,
  output logic [RW-1:0] code
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] inc;

  always_comb begin
    inc = '0;
    for (int i = 0; i < K; i++) inc = inc + CW'(fire[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else          count_q <= count_q + inc;
  end

  assign code = count_q[RW-1:0];

  // R4: the tripped count never exceeds the number of inputs
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(K));
endmodule

// File: rtl/rsort_rank_scan.sv
module rsort_rank_scan #(
  parameter int K = 4,
  parameter int N = 4,
  localparam int RW = (K > 1) ? $clog2(K) : 1,
  localparam int CW = $clog2(K + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [K*N-1:0]  din,
  output logic [K*RW-1:0] rank,
  output logic            done
);
  logic [N:0]    ramp;
  logic          scan_en;
  logic          clr;
  logic [K-1:0]  fire;
  logic [K-1:0]  fired;
  logic [RW-1:0] code;

  rsort_ramp #(.N(N)) u_ramp (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ramp(ramp), .scan_en(scan_en), .clr(clr), .done(done)
  );

  rsort_popcnt #(.K(K), .CW(CW), .RW(RW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire), .code(code)
  );

  for (genvar g = 0; g < K; g++) begin : g_cell
    rsort_cell #(.N(N), .RW(RW)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(scan_en),
      .ramp(ramp), .din(din[g*N +: N]), .code(code),
      .fire(fire[g]), .fired(fired[g]), .rank(rank[g*RW +: RW])
    );
  end

  // R5: every detector, zero inputs included, has tripped by done
  a_r5_all_fired_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&fired));
endmodule

// File: tb/rsort_rank_scan_tb.sv
module rsort_rank_scan_tb;
  localparam int K  = 4;
  localparam int N  = 4;
  localparam int RW = 2;
  localparam int FS = 1 << N;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [K*N-1:0]  din = '0;
  logic [K*RW-1:0] rank;
  logic            done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic done_d = 1'b0;

  logic [K*RW-1:0] exp_q[$];
  int              t0_q[$];
  string           tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rsort_rank_scan #(.K(K), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .rank(rank), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares results at the rising edge of done
  always @(negedge clk) begin
    if (rst_n && done && !done_d) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected done", 1, 0);
      end else begin
        logic [K*RW-1:0] e;
        int t0;
        string tg;
        e = exp_q.pop_front();
        t0 = t0_q.pop_front();
        tg = tag_q.pop_front();
        check(rank == e, tg, rank, e);
        check(cyc - t0 == FS + 1, "R2 done latency", cyc - t0, FS + 1);
      end
    end
    done_d = done;
  end

  task automatic sort(input int a, input int b, input int c, input int d,
                      input bit mid, input string tag);
    int v[K];
    logic [K*RW-1:0] e;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    e = '0;
    for (int i = 0; i < K; i++) begin
      int cnt = 0;
      for (int j = 0; j < K; j++) if (v[j] > v[i]) cnt++;
      e[i*RW +: RW] = RW'(cnt);
      din[i*N +: N] = N'(v[i]);
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    exp_q.push_back(e);
    t0_q.push_back(cyc);
    tag_q.push_back(tag);
    check(done == 1'b0, "R8 done cleared by start", done, 0);
    if (mid) begin
      repeat (5) @(negedge clk);
      start = 1'b1;  // R7: pulse inside the scan
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    check(done && rank == e, "R6 results held", {done, rank}, {1'b1, e});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && rank == '0, "R1 reset state", {done, rank}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && rank == '0, "R1 after release", {done, rank}, 0);
        sort(9, 3, 14, 6, 1'b0, "R3 distinct order");
        sort(7, 7, 2, 7, 1'b0, "R4 ties share rank");
        sort(0, 5, 0, 15, 1'b0, "R5 zeros last");
        sort(0, 0, 0, 0, 1'b0, "R5 all zero");
        sort(8, 9, 10, 11, 1'b0, "R9 one LSB apart");
        sort(15, 15, 15, 15, 1'b0, "R4 all max");
        sort(15, 0, 14, 1, 1'b1, "R7 start in scan ignored");
        sort(1, 2, 3, 4, 1'b0, "R8 fresh scan");
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule